// File: doc/BRIEF.md
# Byte/Word Adder with Status Flags

This unit is the add stage of a 16-bit microcontroller datapath. It receives two operands that have already been fetched, a width select (word or byte), a flag that says whether the destination is a register or a memory word, and the byte lane of a memory destination. On an execute strobe it registers the value to write back and the new status word, which holds the carry, zero, negative and overflow flags.

In word mode the full 16-bit sum is produced. In byte mode only an 8-bit sum is formed, and the flags are taken from that 8-bit sum. How the 8-bit sum is placed in the written word depends on the destination:

- For a register, the upper byte is cleared.
- For a memory word, the untouched byte of the stored word is kept. The lane select chooses which byte receives the sum.

Decode, operand fetch, addressing and the bus are handled elsewhere.

Top module: `addFlagUnit`

## Requirements
- R1: After reset, both `result` and `status` read 0x0000.
- R2: In a cycle without `exec`, `result` and `status` keep their values, whatever the other inputs do.
- R3: In word mode (`byteMode`=0), `result` is (`srcOp` + `dstOp`) mod 2^16. The carry flag (status bit 0) is the carry out of bit 15.
- R4: In word mode, the overflow flag (status bit 8) is set exactly when both operands have the same bit 15 and the result bit 15 differs from it. Examples: 0x7FFF+0x0010 gives 0x800F with status 0x0104; 0x8000+0xFF00 gives 0x7F00 with status 0x0101.
- R5: In word mode, the zero flag (status bit 1) is set when the 16-bit result is 0x0000. The negative flag (status bit 2) equals result bit 15.
- R6: In byte mode (`byteMode`=1), the source byte is `srcOp[7:0]`. All four flags are derived from the 8-bit sum alone: carry out of bit 7, zero when the 8-bit sum is 0x00, negative equal to bit 7, and overflow from the bit-7 signs.
- R7: In byte mode with a register destination (`dstIsMem`=0), the destination byte is `dstOp[7:0]` and `result` is {0x00, sum}. Example: 0x7F+0x10 gives 0x008F.
- R8: In byte mode with a memory destination (`dstIsMem`=1) and `oddByte`=0, the destination byte is `dstOp[7:0]` and `result` is {`dstOp[15:8]`, sum}. Example: 0xAA55 plus 1 gives 0xAA56.
- R9: In byte mode with a memory destination and `oddByte`=1, the destination byte is `dstOp[15:8]` and `result` is {sum, `dstOp[7:0]`}. Example: 0xBB55 plus 1 gives 0xBC55.
- R10: Status bits other than 0, 1, 2 and 8 are always zero.
- R11: Adding all-ones (0xFFFF in word mode, 0xFF in byte mode) acts as a decrement. Carry is set exactly when the other operand is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| exec | input | 1 | Execute strobe; registers result and status |
| byteMode | input | 1 | 1 selects the 8-bit operation |
| dstIsMem | input | 1 | 1 when the destination is a memory word |
| oddByte | input | 1 | Byte lane of a memory destination (1 = high byte) |
| srcOp | input | 16 | Source operand |
| dstOp | input | 16 | Destination operand (full stored word for memory) |
| result | output | 16 | Registered write-back value |
| status | output | 16 | Registered status word |

## Verification
All state sits in the two output registers, so a wrong internal value shows at the ports one clock edge after the `exec` that captured it.

Particular errors show up as follows:

- A wrong lane select or merge corrupts the byte that should have been preserved.
- A sign or carry taken from the wrong bit position differs from the reference in the overflow and carry corner vectors.
- A load that ignores `exec` breaks stability in the very next idle cycle.

// File: rtl/addPkg.sv
package addPkg;
  localparam int DATA_W = 16;
  localparam int C_POS  = 0;
  localparam int Z_POS  = 1;
  localparam int N_POS  = 2;
  localparam int V_POS  = 8;

  typedef struct packed {
    logic load;      // capture result and status this cycle
    logic byteOp;    // 8-bit arithmetic
    logic laneHigh;  // destination byte is the upper half
    logic keepOther; // preserve the non-target byte (memory destination)
  } ctrlT;
endpackage

// File: rtl/addCtrl.sv
module addCtrl
  import addPkg::*;
(
  input  logic exec,
  input  logic byteMode,
  input  logic dstIsMem,
  input  logic oddByte,
  output ctrlT ctrl
);
  always_comb begin
    ctrl.load      = exec;
    ctrl.byteOp    = byteMode;
    ctrl.keepOther = byteMode & dstIsMem;
    ctrl.laneHigh  = byteMode & dstIsMem & oddByte;
  end
endmodule

// File: rtl/addDatapath.sv
module addDatapath
  import addPkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlT         ctrl,
  input  logic [W-1:0] srcOp,
  input  logic [W-1:0] dstOp,
  output logic [W-1:0] result,
  output logic [W-1:0] status
);
  localparam int H = W / 2;

  logic [W:0]   wordSum;
  logic [H:0]   byteSum;
  logic [H-1:0] opA;
  logic [H-1:0] opB;
  logic [W-1:0] resNext;
  logic [W-1:0] statNext;
  logic         cFlag, zFlag, nFlag, vFlag;

  always_comb begin
    opA     = srcOp[H-1:0];
    opB     = ctrl.laneHigh ? dstOp[W-1:H] : dstOp[H-1:0];
    wordSum = {1'b0, srcOp} + {1'b0, dstOp};
    byteSum = {1'b0, opA} + {1'b0, opB};

    if (ctrl.byteOp) begin
      cFlag = byteSum[H];
      zFlag = (byteSum[H-1:0] == '0);
      nFlag = byteSum[H-1];
      vFlag = (opA[H-1] == opB[H-1]) && (byteSum[H-1] != opA[H-1]);
      if (!ctrl.keepOther)
        resNext = {{H{1'b0}}, byteSum[H-1:0]};
      else if (ctrl.laneHigh)
        resNext = {byteSum[H-1:0], dstOp[H-1:0]};
      else
        resNext = {dstOp[W-1:H], byteSum[H-1:0]};
    end else begin
      cFlag   = wordSum[W];
      zFlag   = (wordSum[W-1:0] == '0);
      nFlag   = wordSum[W-1];
      vFlag   = (srcOp[W-1] == dstOp[W-1]) && (wordSum[W-1] != srcOp[W-1]);
      resNext = wordSum[W-1:0];
    end

    statNext        = '0;
    statNext[C_POS] = cFlag;
    statNext[Z_POS] = zFlag;
    statNext[N_POS] = nFlag;
    statNext[V_POS] = vFlag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result <= '0;
      status <= '0;
    end else if (ctrl.load) begin
      result <= resNext;
      status <= statNext;
    end
  end
endmodule

// File: rtl/addFlagUnit.sv
module addFlagUnit
  import addPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        exec,
  input  logic        byteMode,
  input  logic        dstIsMem,
  input  logic        oddByte,
  input  logic [15:0] srcOp,
  input  logic [15:0] dstOp,
  output logic [15:0] result,
  output logic [15:0] status
);
  ctrlT ctrl;

  addCtrl u_ctrl (
    .exec(exec), .byteMode(byteMode), .dstIsMem(dstIsMem),
    .oddByte(oddByte), .ctrl(ctrl)
  );

  addDatapath #(.W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .srcOp(srcOp), .dstOp(dstOp),
    .result(result), .status(status)
  );
endmodule

// File: rtl/addFlagUnitChk.sv
module addFlagUnitChk
  import addPkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        exec,
  input logic        byteMode,
  input logic        dstIsMem,
  input logic        oddByte,
  input logic [15:0] srcOp,
  input logic [15:0] dstOp,
  input logic [15:0] result,
  input logic [15:0] status
);
  logic [15:0] ownedMask;
  always_comb begin
    ownedMask        = '0;
    ownedMask[C_POS] = 1'b1;
    ownedMask[Z_POS] = 1'b1;
    ownedMask[N_POS] = 1'b1;
    ownedMask[V_POS] = 1'b1;
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !exec |=> ($stable(result) && $stable(status)));

  assert_word_zn_R5: assert property (@(posedge clk) disable iff (!rstN)
    (exec && !byteMode) |=>
      (status[Z_POS] == (result == 16'h0000)) && (status[N_POS] == result[15]));

  assert_byte_flags_R6: assert property (@(posedge clk) disable iff (!rstN)
    (exec && byteMode && !dstIsMem) |=>
      (status[Z_POS] == (result[7:0] == 8'h00)) && (status[N_POS] == result[7]));

  assert_reg_upper_R7: assert property (@(posedge clk) disable iff (!rstN)
    (exec && byteMode && !dstIsMem) |=> (result[15:8] == 8'h00));

  assert_even_keep_R8: assert property (@(posedge clk) disable iff (!rstN)
    (exec && byteMode && dstIsMem && !oddByte) |=> (result[15:8] == $past(dstOp[15:8])));

  assert_odd_keep_R9: assert property (@(posedge clk) disable iff (!rstN)
    (exec && byteMode && dstIsMem && oddByte) |=> (result[7:0] == $past(dstOp[7:0])));

  assert_unowned_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (status & ~ownedMask) == 16'h0000);

  assert_word_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    (exec && !byteMode && (srcOp[15] != dstOp[15])) |=> !status[V_POS]);
endmodule

bind addFlagUnit addFlagUnitChk u_chk (
  .clk(clk), .rstN(rstN), .exec(exec), .byteMode(byteMode), .dstIsMem(dstIsMem),
  .oddByte(oddByte), .srcOp(srcOp), .dstOp(dstOp), .result(result), .status(status)
);

// File: tb/addFlagUnit_tb.sv
module addFlagUnit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        exec = 1'b0;
  logic        byteMode = 1'b0;
  logic        dstIsMem = 1'b0;
  logic        oddByte = 1'b0;
  logic [15:0] srcOp = '0;
  logic [15:0] dstOp = '0;
  logic [15:0] result;
  logic [15:0] status;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  addFlagUnit u_dut (
    .clk(clk), .rstN(rstN), .exec(exec), .byteMode(byteMode), .dstIsMem(dstIsMem),
    .oddByte(oddByte), .srcOp(srcOp), .dstOp(dstOp), .result(result), .status(status)
  );

  // {byteMode, dstIsMem, oddByte, src, dst, expected result, expected status}
  localparam logic [66:0] VECS [15] = '{
    {3'b000, 16'h0111, 16'h0888, 16'h0999, 16'h0000}, // R3 no flags
    {3'b000, 16'hFFFF, 16'h0002, 16'h0001, 16'h0001}, // R3 R11 carry
    {3'b000, 16'h0000, 16'h0000, 16'h0000, 16'h0002}, // R5 zero
    {3'b000, 16'hFF00, 16'h0010, 16'hFF10, 16'h0004}, // R5 negative
    {3'b000, 16'h7FFF, 16'h0010, 16'h800F, 16'h0104}, // R4 V N
    {3'b000, 16'h8000, 16'hFF00, 16'h7F00, 16'h0101}, // R4 V C
    {3'b000, 16'hFFFF, 16'h0000, 16'hFFFF, 16'h0004}, // R11 decrement of zero
    {3'b100, 16'h0003, 16'h1206, 16'h0009, 16'h0000}, // R6 R7
    {3'b100, 16'h00FF, 16'h5502, 16'h0001, 16'h0001}, // R6 R11 byte carry
    {3'b100, 16'hAB10, 16'hCD7F, 16'h008F, 16'h0104}, // R6 R7 V N
    {3'b100, 16'h0080, 16'h00FF, 16'h007F, 16'h0101}, // R6 V C
    {3'b110, 16'h0001, 16'hAA55, 16'hAA56, 16'h0000}, // R8
    {3'b111, 16'h0001, 16'hBB55, 16'hBC55, 16'h0004}, // R9
    {3'b111, 16'h00FF, 16'h3355, 16'h3255, 16'h0001}, // R9 R11
    {3'b110, 16'h0001, 16'h77FF, 16'h7700, 16'h0003}  // R8 R6 C Z
  };

  function automatic logic [31:0] refAdd(input logic bm, input logic mem, input logic odd,
                                         input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s17;
    logic [8:0]  s9;
    logic [7:0]  db;
    logic [15:0] r;
    logic [15:0] st;
    st = '0;
    if (!bm) begin
      s17   = {1'b0, a} + {1'b0, b};
      r     = s17[15:0];
      st[0] = s17[16];
      st[1] = (r == 0);
      st[2] = r[15];
      st[8] = (a[15] == b[15]) && (r[15] != a[15]);
    end else begin
      db    = (mem && odd) ? b[15:8] : b[7:0];
      s9    = {1'b0, a[7:0]} + {1'b0, db};
      st[0] = s9[8];
      st[1] = (s9[7:0] == 0);
      st[2] = s9[7];
      st[8] = (a[7] == db[7]) && (s9[7] != a[7]);
      if (!mem)    r = {8'h00, s9[7:0]};
      else if (odd) r = {s9[7:0], b[7:0]};
      else         r = {b[15:8], s9[7:0]};
    end
    return {r, st};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic bm, input logic mem, input logic odd,
                       input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    byteMode = bm; dstIsMem = mem; oddByte = odd; srcOp = a; dstOp = b; exec = 1'b1;
    @(negedge clk);
    exec = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] exp;
    logic [15:0] holdRes, holdStat;
    repeat (3) @(negedge clk);
    check("R1 reset result", result, 16'h0000);
    check("R1 reset status", status, 16'h0000);
    rstN = 1'b1;

    for (int i = 0; i < 15; i++) begin
      apply(VECS[i][66], VECS[i][65], VECS[i][64], VECS[i][63:48], VECS[i][47:32]);
      check($sformatf("R3-table row %0d result", i), result, VECS[i][31:16]);
      check($sformatf("R4-table row %0d status", i), status, VECS[i][15:0]);
    end

    for (int i = 0; i < 400; i++) begin
      logic bm, mem, odd;
      logic [15:0] a, b;
      bm = 1'($urandom); mem = 1'($urandom); odd = 1'($urandom);
      a = 16'($urandom); b = 16'($urandom);
      if (i % 7 == 0) a = bm ? 16'h00FF : 16'hFFFF; // R11 decrement
      apply(bm, mem, odd, a, b);
      exp = refAdd(bm, mem, odd, a, b);
      check("R6 random result", result, exp[31:16]);
      check("R10 random status", status, exp[15:0]);
    end

    // R2: inputs change without exec, outputs must stay
    apply(1'b0, 1'b0, 1'b0, 16'h7FFF, 16'h0010);
    holdRes = result; holdStat = status;
    @(negedge clk);
    srcOp = 16'h1234; dstOp = 16'h4321; byteMode = 1'b1; dstIsMem = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 hold result", result, holdRes);
    check("R2 hold status", status, holdStat);

    // R11 directed: 0x00FF byte added to zero byte gives 0xFF, no carry
    apply(1'b1, 1'b0, 1'b0, 16'h00FF, 16'h9900);
    check("R11 byte dec zero result", result, 16'h00FF);
    check("R11 byte dec zero status", status, 16'h0004);

    // R1: reset again clears registers
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    check("R1 re-reset result", result, 16'h0000);
    check("R1 re-reset status", status, 16'h0000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule